// File: doc/BRIEF.md
# Four-Slot Bit Timing Recovery Controller

This block recovers bit timing for a time-division receiver that serves up to four slots. A hard-decision bit stream arrives at the master clock rate, which is 50 clocks per bit. For every slot the block keeps its own digital phase-locked counter and its own stored frequency-error value. Because each slot has its own context, a receiver that hops between slots finds the timing and frequency state of each slot where it left it.

A two-bit slot select chooses the active context. The recovered clock, the recovered data and the stored frequency error of that context reach the outputs through a purely combinational path. Only the active context sees line transitions, so only the active context corrects its phase or estimates its frequency error. The other enabled contexts keep counting freely. When the mode input is low, only the first two contexts run.

Three control inputs steer the loop. A fast-acquire input selects coarse phase steps until the loop is close to lock. A run input enables phase correction or freezes it. An AFC input lets the frequency-error estimate update; when it is low, the stored value is held and is still applied.

Top module: `slot_clock_recovery`

## Requirements
- R1: Slot select value 0, 1, 2 or 3 makes context 0, 1, 2 or 3 active (slots 1 to 4). The outputs follow a change of the select combinationally, within the same clock cycle.
- R2: With `cell_mode` high, all four contexts run. With `cell_mode` low, contexts 2 and 3 hold all of their state, so a selected frozen context shows a constant recovered clock.
- R3: The bit counter runs from 0 to 49 and then wraps. `rec_clk` is high while the active count is 25 to 49. `rec_data` loads `rx_bit` on the clock edge where the active count is 25 and holds that value between captures.
- R4: A line transition is a clock edge on which `rx_bit` differs from its value at the previous edge. The phase error is e = count if count < 25, otherwise count − 50. With `run_en` and `fast_acq` high and the context not yet locked, a transition with |e| > 2 moves the count by 4 against the sign of e. For example, e = 10 stretches that bit period to 54 clocks, and e = −10 shortens it to 46 clocks.
- R5: In fast mode, a transition with |e| ≤ 2 locks the context. That transition and all later ones use 1-count steps until `fast_acq` goes low while the context is active, which re-arms coarse steps.
- R6: With `fast_acq` low, every correction is 1 count (e = 10 gives 51 clocks, e = −10 gives 49).
- R7: With `run_en` low, transitions cause no phase correction and the bit period stays at 50 clocks.
- R8: On the first clock where `afc_en` and `fast_acq` are both high, the active context clears its frequency error and averaging state. It then ignores transitions for estimation during the next 100 clocks.
- R9: With `afc_en` high, the phase errors of the active context are summed over windows of 4 transitions when `fast_acq` is high, or 32 transitions when it is low. At the end of a window the stored signed 8-bit error becomes the sum arithmetically shifted right by 2 or by 5.
- R10: With `afc_en` low, the stored error does not change. At every wrap, a positive stored error shortens the bit period to 49 clocks and a negative one lengthens it to 51.
- R11: After reset, all counts, stored errors, lock flags and data are zero, so `rec_clk`, `rec_data` and `freq_err` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 50 clocks per bit |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_sel | input | 2 | Active context select |
| cell_mode | input | 1 | 1: four contexts run, 0: only contexts 0 and 1 run |
| fast_acq | input | 1 | Coarse phase acquisition and short averaging window |
| run_en | input | 1 | Enables phase correction |
| afc_en | input | 1 | Enables frequency-error estimation |
| rx_bit | input | 1 | Hard-decision received bit stream |
| rec_clk | output | 1 | Recovered bit clock of the active context |
| rec_data | output | 1 | Recovered data of the active context |
| freq_err | output | 8 | Stored signed frequency error of the active context |

## Verification
Two functions can act on the counter in the same cycle: the wrap adjustment driven by the stored frequency error, and phase correction or estimation driven by a transition. Both also interact with a window update that lands on the clock where a new estimate first takes effect. The bench places transitions at exact counter offsets after an observed rising edge of `rec_clk`. It lets a window close on a transition whose bit period then contains a stretched or shortened wrap, and it judges each case by the measured rise-to-rise period and the value read on `freq_err`. Holdoff and averaging meet when the AFC clear lands while transitions keep arriving; the estimate must reflect only the transitions that fall after the 100-clock window.

// File: rtl/scr_pkg.sv
// Shared constants and helpers for the slot clock recovery block.
// Assumes one bit period is BIT_CLKS master clocks with the ideal transition at count 0.
package scr_pkg;

    localparam int DEF_BIT_CLKS   = 50;
    localparam int DEF_SAMPLE_PT  = 25;
    localparam int DEF_BIG_STEP   = 4;
    localparam int DEF_SMALL_STEP = 1;
    localparam int DEF_LOCK_WIN   = 2;
    localparam int DEF_FAST_LOG2  = 2;
    localparam int DEF_SLOW_LOG2  = 5;
    localparam int DEF_HOLDOFF    = 100;
    localparam int DEF_ERR_W      = 8;

    // Signed distance of a count from the ideal transition point, folded at mid-period.
    function automatic int phase_err(input int count, input int period, input int mid);
        if (count < mid) return count;
        return count - period;
    endfunction

endpackage

// File: rtl/scr_edge_detect.sv
// Detects a change of the received bit between clock edges and reports the phase
// error of the active counter at that edge. Assumes rx_bit is already synchronous.
module scr_edge_detect #(
    parameter int BIT_CLKS  = scr_pkg::DEF_BIT_CLKS,
    parameter int SAMPLE_PT = scr_pkg::DEF_SAMPLE_PT,
    parameter int CNT_W     = $clog2(BIT_CLKS),
    parameter int PERR_W    = CNT_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_bit,
    input  logic [CNT_W-1:0]         act_cnt,
    output logic                     edge_seen,
    output logic signed [PERR_W-1:0] perr
);

    logic prev_q;

    // Remember the bit seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= rx_bit;
    end

    // Transition flag and folded phase error of the active counter.
    always_comb begin
        edge_seen = rx_bit ^ prev_q;
        perr      = PERR_W'(scr_pkg::phase_err(int'(act_cnt), BIT_CLKS, SAMPLE_PT));
    end

endmodule

// File: rtl/scr_clear_gen.sv
// Produces a one-clock clear request when AFC enable and fast acquire first
// coincide. Assumes both inputs are synchronous to clk.
module scr_clear_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic afc_en,
    input  logic fast_acq,
    output logic afc_clr
);

    logic both_q;

    // Track the previous coincidence of the two inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) both_q <= 1'b0;
        else        both_q <= afc_en & fast_acq;
    end

    // Clear only on the first clock of the coincidence.
    always_comb afc_clr = afc_en & fast_acq & ~both_q;

    a_r8_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        afc_clr |=> !afc_clr);

endmodule

// File: rtl/scr_slot_ctx.sv
// One slot context: bit counter with phase correction, lock flag, frequency-error
// averaging with holdoff, and data capture. Assumes edge and error inputs are
// shared and that only the context flagged active may use them.
module scr_slot_ctx #(
    parameter int BIT_CLKS   = scr_pkg::DEF_BIT_CLKS,
    parameter int SAMPLE_PT  = scr_pkg::DEF_SAMPLE_PT,
    parameter int BIG_STEP   = scr_pkg::DEF_BIG_STEP,
    parameter int SMALL_STEP = scr_pkg::DEF_SMALL_STEP,
    parameter int LOCK_WIN   = scr_pkg::DEF_LOCK_WIN,
    parameter int FAST_LOG2  = scr_pkg::DEF_FAST_LOG2,
    parameter int SLOW_LOG2  = scr_pkg::DEF_SLOW_LOG2,
    parameter int HOLDOFF    = scr_pkg::DEF_HOLDOFF,
    parameter int ERR_W      = scr_pkg::DEF_ERR_W,
    parameter int CNT_W      = $clog2(BIT_CLKS),
    parameter int PERR_W     = CNT_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     active,
    input  logic                     edge_seen,
    input  logic signed [PERR_W-1:0] perr,
    input  logic                     rx_bit,
    input  logic                     run_en,
    input  logic                     fast_acq,
    input  logic                     afc_en,
    input  logic                     afc_clr,
    output logic [CNT_W-1:0]         cnt_q,
    output logic                     data_q,
    output logic signed [ERR_W-1:0]  ferr_q
);

    localparam int LAST  = BIT_CLKS - 1;
    localparam int ACC_W = PERR_W + SLOW_LOG2;
    localparam int HO_W  = $clog2(HOLDOFF + 1);
    localparam logic [SLOW_LOG2-1:0] FAST_MAX = SLOW_LOG2'((2 ** FAST_LOG2) - 1);
    localparam logic [SLOW_LOG2-1:0] SLOW_MAX = SLOW_LOG2'((2 ** SLOW_LOG2) - 1);

    logic                    stretch_q, stretch_d;
    logic                    locked_q;
    logic signed [ACC_W-1:0] acc_q, acc_sum;
    logic [SLOW_LOG2-1:0]    acc_n_q, win_last;
    logic [HO_W-1:0]         hold_q;
    logic [CNT_W-1:0]        cnt_d;
    logic                    corr_en, est_go, near;
    logic signed [ERR_W-1:0] ferr_d;
    int                      mag;

    // Correction and estimation qualifiers for this context.
    always_comb begin
        mag      = (perr < 0) ? -int'(perr) : int'(perr);
        near     = (mag <= LOCK_WIN);
        corr_en  = active & edge_seen & run_en;
        est_go   = active & edge_seen & afc_en & (hold_q == '0);
        win_last = fast_acq ? FAST_MAX : SLOW_MAX;
        acc_sum  = acc_q + ACC_W'(perr);
        ferr_d   = ERR_W'(acc_sum >>> (fast_acq ? FAST_LOG2 : SLOW_LOG2));
    end

    // Next count: wrap with frequency adjustment, then phase step.
    always_comb begin
        int base;
        int step;
        int tmp;
        stretch_d = stretch_q;
        if (int'(cnt_q) == LAST) begin
            if (ferr_q > 0) begin
                base      = 1;
                stretch_d = 1'b0;
            end else if ((ferr_q < 0) && !stretch_q) begin
                base      = LAST;
                stretch_d = 1'b1;
            end else begin
                base      = 0;
                stretch_d = 1'b0;
            end
        end else begin
            base = int'(cnt_q) + 1;
        end
        step = (fast_acq && !locked_q && !near) ? BIG_STEP : SMALL_STEP;
        tmp  = base;
        if (corr_en && (perr > 0))      tmp = base + BIT_CLKS - step;
        else if (corr_en && (perr < 0)) tmp = base + step;
        if (tmp >= BIT_CLKS) tmp = tmp - BIT_CLKS;
        cnt_d = CNT_W'(tmp);
    end

    // Counter and wrap-stretch state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            stretch_q <= 1'b0;
        end else if (en) begin
            cnt_q     <= cnt_d;
            stretch_q <= stretch_d;
        end
    end

    // Lock flag: set near zero error in fast mode, cleared while fast mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (en && active) begin
            if (!fast_acq)                   locked_q <= 1'b0;
            else if (corr_en && near)        locked_q <= 1'b1;
        end
    end

    // Frequency-error clear, holdoff and windowed averaging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ferr_q  <= '0;
            acc_q   <= '0;
            acc_n_q <= '0;
            hold_q  <= '0;
        end else if (en) begin
            if (active && afc_clr) begin
                ferr_q  <= '0;
                acc_q   <= '0;
                acc_n_q <= '0;
                hold_q  <= HO_W'(HOLDOFF);
            end else begin
                if (hold_q != '0) hold_q <= hold_q - 1'b1;
                if (est_go) begin
                    if (acc_n_q >= win_last) begin
                        ferr_q  <= ferr_d;
                        acc_q   <= '0;
                        acc_n_q <= '0;
                    end else begin
                        acc_q   <= acc_sum;
                        acc_n_q <= acc_n_q + 1'b1;
                    end
                end
            end
        end
    end

    // Recovered data capture at the sampling count.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         data_q <= 1'b0;
        else if (en && active && int'(cnt_q) == SAMPLE_PT)  data_q <= rx_bit;
    end

    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < BIT_CLKS);

    a_r7_free_run: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !(active && edge_seen && run_en) && int'(cnt_q) != LAST)
        |=> cnt_q == $past(cnt_q) + 1'b1);

    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(cnt_q) && $stable(ferr_q)));

    a_r10_hold_err: assert property (@(posedge clk) disable iff (!rst_n)
        !afc_en |=> $stable(ferr_q));

    a_r8_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != '0) |=> $stable(acc_n_q));

    a_r5_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (en && active && !fast_acq) |=> !locked_q);

endmodule

// File: rtl/slot_clock_recovery.sv
// Top of the four-slot bit timing recovery controller. Builds one context per slot,
// shares transition detection, and routes the selected context to the outputs
// combinationally. Assumes all inputs are synchronous to clk.
module slot_clock_recovery #(
    parameter int NUM_SLOTS  = 4,
    parameter int PS_SLOTS   = 2,
    parameter int BIT_CLKS   = scr_pkg::DEF_BIT_CLKS,
    parameter int SAMPLE_PT  = scr_pkg::DEF_SAMPLE_PT,
    parameter int BIG_STEP   = scr_pkg::DEF_BIG_STEP,
    parameter int SMALL_STEP = scr_pkg::DEF_SMALL_STEP,
    parameter int LOCK_WIN   = scr_pkg::DEF_LOCK_WIN,
    parameter int FAST_LOG2  = scr_pkg::DEF_FAST_LOG2,
    parameter int SLOW_LOG2  = scr_pkg::DEF_SLOW_LOG2,
    parameter int HOLDOFF    = scr_pkg::DEF_HOLDOFF,
    parameter int ERR_W      = scr_pkg::DEF_ERR_W,
    parameter int SEL_W      = $clog2(NUM_SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SEL_W-1:0]        slot_sel,
    input  logic                    cell_mode,
    input  logic                    fast_acq,
    input  logic                    run_en,
    input  logic                    afc_en,
    input  logic                    rx_bit,
    output logic                    rec_clk,
    output logic                    rec_data,
    output logic signed [ERR_W-1:0] freq_err
);

    localparam int CNT_W  = $clog2(BIT_CLKS);
    localparam int PERR_W = CNT_W + 1;

    logic [CNT_W-1:0]        cnt_a  [NUM_SLOTS];
    logic                    data_a [NUM_SLOTS];
    logic signed [ERR_W-1:0] ferr_a [NUM_SLOTS];
    logic [CNT_W-1:0]        act_cnt;
    logic                    edge_seen, afc_clr;
    logic signed [PERR_W-1:0] perr;

    scr_edge_detect #(
        .BIT_CLKS(BIT_CLKS), .SAMPLE_PT(SAMPLE_PT), .CNT_W(CNT_W), .PERR_W(PERR_W)
    ) u_edge (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .act_cnt(act_cnt),
        .edge_seen(edge_seen), .perr(perr)
    );

    scr_clear_gen u_clr (
        .clk(clk), .rst_n(rst_n), .afc_en(afc_en), .fast_acq(fast_acq), .afc_clr(afc_clr)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam bit ALWAYS_ON = (s < PS_SLOTS);
        logic slot_en, slot_act;

        // Context enable by station mode and activity by slot select.
        always_comb begin
            slot_en  = cell_mode | ALWAYS_ON;
            slot_act = (slot_sel == SEL_W'(s));
        end

        scr_slot_ctx #(
            .BIT_CLKS(BIT_CLKS), .SAMPLE_PT(SAMPLE_PT), .BIG_STEP(BIG_STEP),
            .SMALL_STEP(SMALL_STEP), .LOCK_WIN(LOCK_WIN), .FAST_LOG2(FAST_LOG2),
            .SLOW_LOG2(SLOW_LOG2), .HOLDOFF(HOLDOFF), .ERR_W(ERR_W),
            .CNT_W(CNT_W), .PERR_W(PERR_W)
        ) u_ctx (
            .clk(clk), .rst_n(rst_n), .en(slot_en), .active(slot_act),
            .edge_seen(edge_seen), .perr(perr), .rx_bit(rx_bit), .run_en(run_en),
            .fast_acq(fast_acq), .afc_en(afc_en), .afc_clr(afc_clr),
            .cnt_q(cnt_a[s]), .data_q(data_a[s]), .ferr_q(ferr_a[s])
        );
    end

    // Combinational routing of the selected context to the outputs.
    always_comb begin
        act_cnt  = cnt_a[slot_sel];
        rec_clk  = (int'(act_cnt) >= SAMPLE_PT);
        rec_data = data_a[slot_sel];
        freq_err = ferr_a[slot_sel];
    end

endmodule

// File: tb/slot_clock_recovery_test.sv
`timescale 1ns/1ps
module slot_clock_recovery_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        slot_sel = 2'd0;
    logic              cell_mode = 1'b1;
    logic              fast_acq = 1'b0;
    logic              run_en = 1'b0;
    logic              afc_en = 1'b0;
    logic              rx_bit = 1'b0;
    logic              rec_clk, rec_data;
    logic signed [7:0] freq_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    slot_clock_recovery uut (
        .clk(clk), .rst_n(rst_n), .slot_sel(slot_sel), .cell_mode(cell_mode),
        .fast_acq(fast_acq), .run_en(run_en), .afc_en(afc_en), .rx_bit(rx_bit),
        .rec_clk(rec_clk), .rec_data(rec_data), .freq_err(freq_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sync_rise();
        logic last;
        last = rec_clk;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rec_clk && !last) break;
            last = rec_clk;
        end
    endtask

    // Starting at a rise, toggle rx_bit d negedges later; return clocks to next rise.
    task automatic period(input int d, output int n);
        logic last;
        last = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == d) rx_bit = ~rx_bit;
            if (rec_clk && !last) break;
            last = rec_clk;
            if (n > 500) break;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(rec_clk == 1'b0, "R11 rec_clk", int'(rec_clk), 0);
        check(rec_data == 1'b0, "R11 rec_data", int'(rec_data), 0);
        check(freq_err == 8'sd0, "R11 freq_err", int'(freq_err), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_sample();
        int h;
        sync_rise();
        rx_bit = 1'b1;
        @(negedge clk);
        check(rec_data == 1'b1, "R3 capture at count 25", int'(rec_data), 1);
        @(negedge clk);
        rx_bit = 1'b0;
        repeat (20) @(negedge clk);
        check(rec_data == 1'b1, "R3 hold between captures", int'(rec_data), 1);
        sync_rise();
        h = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (rec_clk) h++;
            else break;
        end
        check(h == 25, "R3 rec_clk high time", h, 25);
        check(rec_data == 1'b0, "R3 new capture", int'(rec_data), 0);
    endtask

    task automatic t_fast();
        int p;
        run_en = 1'b1;
        fast_acq = 1'b1;
        sync_rise();
        period(35, p); check(p == 54, "R4 coarse step e=10", p, 54);
        period(15, p); check(p == 46, "R4 coarse step e=-10", p, 46);
        period(27, p); check(p == 51, "R5 lock edge e=2", p, 51);
        period(35, p); check(p == 51, "R5 fine after lock", p, 51);
        fast_acq = 1'b0;
        period(15, p); check(p == 49, "R6 slow step e=-10", p, 49);
        period(35, p); check(p == 51, "R6 slow step e=10", p, 51);
        fast_acq = 1'b1;
        period(35, p); check(p == 54, "R5 coarse re-armed", p, 54);
        run_en = 1'b0;
        period(35, p); check(p == 50, "R7 no correction", p, 50);
    endtask

    task automatic t_fast_avg();
        int p;
        sync_rise();
        afc_en = 1'b1;
        period(28, p);
        period(28, p);
        check(freq_err == 8'sd0, "R8 holdoff ignores edges", int'(freq_err), 0);
        period(28, p);
        period(28, p);
        period(28, p);
        check(freq_err == 8'sd0, "R9 fast window not full", int'(freq_err), 0);
        period(28, p);
        check(freq_err == 8'sd3, "R9 fast window average", int'(freq_err), 3);
        period(1000, p); check(p == 49, "R10 positive error shortens", p, 49);
    endtask

    task automatic t_slow_avg();
        int p;
        afc_en = 1'b0;
        @(negedge clk);
        afc_en = 1'b1;
        sync_rise();
        period(1000, p);
        period(1000, p);
        check(freq_err == 8'sd0, "R8 clear on coincidence", int'(freq_err), 0);
        fast_acq = 1'b0;
        for (int i = 0; i < 31; i++) period(20, p);
        check(freq_err == 8'sd0, "R9 slow window not full", int'(freq_err), 0);
        period(20, p);
        check(freq_err == -8'sd5, "R9 slow window average", int'(freq_err), -5);
        afc_en = 1'b0;
        period(35, p); check(p == 51, "R10 negative error lengthens", p, 51);
        check(freq_err == -8'sd5, "R10 held without AFC", int'(freq_err), -5);
    endtask

    task automatic t_select();
        @(negedge clk);
        slot_sel = 2'd1;
        #1;
        check(freq_err == 8'sd0, "R1 select slot 2", int'(freq_err), 0);
        slot_sel = 2'd0;
        #1;
        check(freq_err == -8'sd5, "R1 select slot 1", int'(freq_err), -5);
    endtask

    task automatic t_personal();
        logic v;
        bit changed;
        bit seen;
        @(negedge clk);
        cell_mode = 1'b0;
        slot_sel = 2'd2;
        #1;
        v = rec_clk;
        changed = 1'b0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (rec_clk != v) changed = 1'b1;
        end
        check(!changed, "R2 context 2 frozen", int'(changed), 0);
        cell_mode = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rec_clk != v) seen = 1'b1;
        end
        check(seen, "R2 context 2 runs in cell mode", int'(seen), 1);
    endtask

    initial begin
        t_reset();
        t_sample();
        t_fast();
        t_fast_avg();
        t_slow_avg();
        t_select();
        t_personal();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule